// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block carries out the memory work of entering an interrupt on a 16-bit real-address-mode core. The core offers an entry request carrying the vector number, a flag that marks a software-raised interrupt, the current and following instruction offsets, the current code segment, the flags word, the full stack pointer and the stack segment base. Once it accepts the request, the block fetches the two-word vector from the table at `TBL_BASE`. It then writes a three-word return frame below the stack pointer and reports the new code segment, instruction offset and stack pointer.

All memory traffic uses a single word-wide port with byte addresses. Each access is one request held until it is acknowledged. The request side follows valid/ready rules. `start_ready` is high only when no sequence is in flight, which is the idle state or the single cycle in which `done` is high. A request is taken on a rising edge where both `start_valid` and `start_ready` are high. Every request field is captured at that edge, so later changes on those inputs have no effect. On the memory side, `mem_ack` is the back-pressure. While it is low, the block keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged.

Top module: `rmi_entry_seq`

## Requirements
- R1: `start_ready` is high exactly when no sequence is running. `mem_req` is never high in a cycle where `start_ready` is high, and no memory access occurs without an accepted request.
- R2: The first access is a read at `TBL_BASE + 4*vec_num`. The second access is a read at that address plus 2.
- R3: The word returned by the first read becomes `new_ip`, and the word returned by the second read becomes `new_cs`.
- R4: Accesses three to five are writes, in this order: the flags word, the old code segment, the saved instruction offset. The k-th write (k = 1, 2, 3) goes to `ss_base + ((cur_sp[15:0] - 2k) mod 65536)`, so the address wraps inside a 64 KiB window.
- R5: The saved instruction offset is `next_ip` when `soft_int` is 1 and `cur_ip` when it is 0.
- R6: `new_sp` equals `{cur_sp[31:16], cur_sp[15:0] - 6}`, with the low half wrapping modulo 65536.
- R7: While `mem_req` is high and `mem_ack` is low, the request fields stay unchanged. The block waits for as many cycles as acknowledgement takes.
- R8: `done` is high for exactly one cycle, in the cycle right after the acknowledged third write. `new_ip`, `new_cs` and `new_sp` are valid in that cycle.
- R9: After reset, `start_ready` is 1, `mem_req` and `done` are 0, and `new_ip`, `new_cs` and `new_sp` are 0.
- R10: Request fields that change after acceptance, while a sequence runs, do not alter any access or result of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Entry request offered |
| start_ready | output | 1 | Block can take a request this cycle |
| vec_num | input | VEC_W | Interrupt vector number |
| soft_int | input | 1 | 1 = software-raised interrupt |
| cur_ip | input | 16 | Offset of the current instruction |
| next_ip | input | 16 | Offset of the following instruction |
| cur_cs | input | 16 | Current code segment |
| cur_flags | input | 16 | Flags word to save |
| cur_sp | input | SP_W | Full stack pointer |
| ss_base | input | ADDR_W | Stack segment byte base |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 16 | Write word |
| mem_ack | input | 1 | Access completes on this edge |
| mem_rdata | input | 16 | Read word, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| new_cs | output | 16 | Code segment from the vector |
| new_ip | output | 16 | Offset from the vector |
| new_sp | output | SP_W | Stack pointer after the pushes |

## Verification
Two events can fall in the same cycle. One is the completion pulse of one sequence. The other is the acceptance of the next request, because the block is ready again in its `done` cycle. The bench provokes this overlap by keeping `start_valid` high with a fresh request while the previous sequence is still running. It then judges that the completion results belong to the old request, and that the next vector read uses the new request's number on the following cycle. A second overlap is an acknowledgement that arrives in the same cycle as its request. Zero-wait table rows exercise it, and each access is checked against its expected address and data.

// File: rtl/rmi_pkg.sv
package rmi_pkg;
  localparam int WORD_W = 16;
  localparam int PUSH_N = 3;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_IP = 3'd1,
    ST_RD_CS = 3'd2,
    ST_WR_FL = 3'd3,
    ST_WR_CS = 3'd4,
    ST_WR_IP = 3'd5,
    ST_DONE  = 3'd6
  } rmi_state_e;
endpackage

// File: rtl/rmi_ctrl.sv
module rmi_ctrl
  import rmi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_valid,
  input  logic       mem_ack,
  output rmi_state_e state,
  output logic       start_ready,
  output logic       accept,
  output logic       mem_req,
  output logic       beat,
  output logic       done
);
  rmi_state_e state_q, state_d;

  always_comb begin
    start_ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
    accept      = start_valid && start_ready;
    mem_req     = (state_q != ST_IDLE) && (state_q != ST_DONE);
    beat        = mem_req && mem_ack;
    done        = (state_q == ST_DONE);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: state_d = accept ? ST_RD_IP : ST_IDLE;
      ST_RD_IP: if (beat) state_d = ST_RD_CS;
      ST_RD_CS: if (beat) state_d = ST_WR_FL;
      ST_WR_FL: if (beat) state_d = ST_WR_CS;
      ST_WR_CS: if (beat) state_d = ST_WR_IP;
      ST_WR_IP: if (beat) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/rmi_addr_gen.sv
module rmi_addr_gen
  import rmi_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          SP_W     = 32,
  parameter int          VEC_W    = 8,
  parameter logic [31:0] TBL_BASE = 32'h0
) (
  input  rmi_state_e          state,
  input  logic [VEC_W-1:0]    vec_q,
  input  logic [ADDR_W-1:0]   ss_base_q,
  input  logic [SP_W-1:0]     sp_q,
  input  logic [WORD_W-1:0]   flags_q,
  input  logic [WORD_W-1:0]   cs_q,
  input  logic [WORD_W-1:0]   ret_ip_q,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic [SP_W-1:0]     sp_out
);
  localparam int ENTRY_SHIFT = 2;
  localparam int STEP_BYTES  = WORD_W / 8;

  logic [ADDR_W-1:0] vec_addr;
  logic [WORD_W-1:0] slot_off  [PUSH_N];
  logic [ADDR_W-1:0] slot_addr [PUSH_N];
  logic [WORD_W-1:0] frame     [PUSH_N];

  assign vec_addr = ADDR_W'(TBL_BASE) + (ADDR_W'(vec_q) << ENTRY_SHIFT);

  always_comb begin
    frame[0] = flags_q;
    frame[1] = cs_q;
    frame[2] = ret_ip_q;
  end

  for (genvar k = 0; k < PUSH_N; k++) begin : g_slot
    assign slot_off[k]  = sp_q[WORD_W-1:0] - WORD_W'(STEP_BYTES * (k + 1));
    assign slot_addr[k] = ss_base_q + ADDR_W'(slot_off[k]);
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_RD_IP: mem_addr = vec_addr;
      ST_RD_CS: mem_addr = vec_addr + ADDR_W'(STEP_BYTES);
      ST_WR_FL: begin mem_we = 1'b1; mem_addr = slot_addr[0]; mem_wdata = frame[0]; end
      ST_WR_CS: begin mem_we = 1'b1; mem_addr = slot_addr[1]; mem_wdata = frame[1]; end
      ST_WR_IP: begin mem_we = 1'b1; mem_addr = slot_addr[2]; mem_wdata = frame[2]; end
      default: ;
    endcase
  end

  assign sp_out = {sp_q[SP_W-1:WORD_W], slot_off[PUSH_N-1]};
endmodule

// File: rtl/rmi_vec_latch.sv
module rmi_vec_latch
  import rmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rmi_state_e        state,
  input  logic              beat,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] ip_q,
  output logic [WORD_W-1:0] cs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q <= '0;
      cs_q <= '0;
    end else if (beat) begin
      if (state == ST_RD_IP) ip_q <= rdata;
      if (state == ST_RD_CS) cs_q <= rdata;
    end
  end
endmodule

// File: rtl/rmi_entry_seq.sv
module rmi_entry_seq
  import rmi_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          SP_W     = 32,
  parameter int          VEC_W    = 8,
  parameter logic [31:0] TBL_BASE = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [VEC_W-1:0]  vec_num,
  input  logic              soft_int,
  input  logic [15:0]       cur_ip,
  input  logic [15:0]       next_ip,
  input  logic [15:0]       cur_cs,
  input  logic [15:0]       cur_flags,
  input  logic [SP_W-1:0]   cur_sp,
  input  logic [ADDR_W-1:0] ss_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic              done,
  output logic [15:0]       new_cs,
  output logic [15:0]       new_ip,
  output logic [SP_W-1:0]   new_sp
);
  rmi_state_e        state;
  logic              accept, beat;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] ss_q;
  logic [SP_W-1:0]   sp_q, sp_next, sp_res_q;
  logic [15:0]       flags_q, cs_q, ret_ip_q;

  rmi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .mem_ack(mem_ack),
    .state(state), .start_ready(start_ready), .accept(accept),
    .mem_req(mem_req), .beat(beat), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q    <= '0;
      ss_q     <= '0;
      sp_q     <= '0;
      flags_q  <= '0;
      cs_q     <= '0;
      ret_ip_q <= '0;
    end else if (accept) begin
      vec_q    <= vec_num;
      ss_q     <= ss_base;
      sp_q     <= cur_sp;
      flags_q  <= cur_flags;
      cs_q     <= cur_cs;
      ret_ip_q <= soft_int ? next_ip : cur_ip;
    end
  end

  rmi_addr_gen #(
    .ADDR_W(ADDR_W), .SP_W(SP_W), .VEC_W(VEC_W), .TBL_BASE(TBL_BASE)
  ) u_addr (
    .state(state), .vec_q(vec_q), .ss_base_q(ss_q), .sp_q(sp_q),
    .flags_q(flags_q), .cs_q(cs_q), .ret_ip_q(ret_ip_q),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_out(sp_next)
  );

  rmi_vec_latch u_vec (
    .clk(clk), .rst_n(rst_n), .state(state), .beat(beat),
    .rdata(mem_rdata), .ip_q(new_ip), .cs_q(new_cs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          sp_res_q <= '0;
    else if (beat && state == ST_WR_IP)  sp_res_q <= sp_next;
  end

  assign new_sp = sp_res_q;
endmodule

// File: rtl/rmi_entry_chk.sv
module rmi_entry_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              done
);
  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !start_ready);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_req && mem_ack && mem_we));

  // R2
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) ##1 (mem_req && !mem_we)
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(2)));
endmodule

bind rmi_entry_seq rmi_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_ready(start_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .done(done)
);

// File: tb/rmi_entry_seq_test.sv
`timescale 1ns/1ps
module rmi_entry_seq_test;
  localparam logic [31:0] TB_TBL = 32'h0000_0400;
  localparam int NJOB = 8;

  typedef struct packed {
    logic [7:0]  vec;
    logic        sw;
    logic [15:0] cip, nip, cs, fl;
    logic [31:0] sp, ss;
    logic [3:0]  wt;
    logic        b2b;
  } job_t;

  localparam job_t JOBS [NJOB] = '{
    '{8'h08, 1'b0, 16'h1234, 16'h1236, 16'hF000, 16'h0202, 32'h0000_FFF0, 32'h0003_0000, 4'd0, 1'b0},
    '{8'h21, 1'b1, 16'h0100, 16'h0102, 16'h1000, 16'h0046, 32'hABCD_0002, 32'h0002_0000, 4'd1, 1'b0},
    '{8'hFF, 1'b1, 16'h7FFE, 16'h8000, 16'h2222, 16'h0893, 32'h1234_0000, 32'h000F_0000, 4'd3, 1'b1},
    '{8'h00, 1'b0, 16'h0004, 16'h0006, 16'h0000, 16'h0000, 32'h0000_0006, 32'h0000_0000, 4'd0, 1'b1},
    '{8'h13, 1'b1, 16'hFFFF, 16'h0001, 16'h3333, 16'h7FD5, 32'hFFFF_8001, 32'h0010_0000, 4'd2, 1'b0},
    '{8'h80, 1'b0, 16'h4444, 16'h4447, 16'h5555, 16'h0F0F, 32'h0000_0004, 32'h0040_0000, 4'd0, 1'b1},
    '{8'h40, 1'b1, 16'h9000, 16'h9002, 16'h6666, 16'hA5A5, 32'h5555_1000, 32'h0001_2340, 4'd5, 1'b0},
    '{8'h01, 1'b0, 16'hBEEF, 16'hBEF1, 16'h7777, 16'h0001, 32'h0000_0100, 32'h0000_8000, 4'd0, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_valid = 1'b0, soft_int = 1'b0;
  logic [7:0]  vec_num = '0;
  logic [15:0] cur_ip = '0, next_ip = '0, cur_cs = '0, cur_flags = '0;
  logic [31:0] cur_sp = '0, ss_base = '0;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        start_ready, mem_req, mem_we, done;
  logic [31:0] mem_addr, new_sp;
  logic [15:0] mem_wdata, new_cs, new_ip;

  int checks = 0, fails = 0;
  int mj = 0, acc_k = 0, wcnt = 0, done_cnt = 0;
  bit last_prev = 1'b0, active = 1'b0;
  logic [31:0] hold_addr; logic [15:0] hold_data; logic hold_we;

  always #2.5 clk = ~clk;

  rmi_entry_seq #(.TBL_BASE(TB_TBL)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .vec_num(vec_num), .soft_int(soft_int), .cur_ip(cur_ip), .next_ip(next_ip),
    .cur_cs(cur_cs), .cur_flags(cur_flags), .cur_sp(cur_sp), .ss_base(ss_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .new_cs(new_cs), .new_ip(new_ip), .new_sp(new_sp)
  );

  function automatic logic [15:0] rd_model(input logic [31:0] a);
    return a[15:0] * 16'd5 + 16'h2468;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // memory responder and result monitor
  always @(negedge clk) begin
    if (rst_n && active) begin
      job_t j;
      logic [31:0] ea; logic [15:0] ed; logic ewe; logic [15:0] saved;
      j = JOBS[mj < NJOB ? mj : NJOB-1];
      if (done) begin
        check(last_prev, "R8 done timing", 32'(done), 32'd1);
        check(new_ip == rd_model(TB_TBL + {22'd0, j.vec, 2'b00}), "R3 new_ip", 32'(new_ip),
              32'(rd_model(TB_TBL + {22'd0, j.vec, 2'b00})));
        check(new_cs == rd_model(TB_TBL + {22'd0, j.vec, 2'b00} + 32'd2), "R3 new_cs", 32'(new_cs),
              32'(rd_model(TB_TBL + {22'd0, j.vec, 2'b00} + 32'd2)));
        check(new_sp == {j.sp[31:16], j.sp[15:0] - 16'd6}, "R6 new_sp", new_sp,
              {j.sp[31:16], j.sp[15:0] - 16'd6});
        mj++; done_cnt++; acc_k = 0;
      end else if (last_prev) begin
        check(1'b0, "R8 done missing", 32'(done), 32'd1);
      end
      last_prev = 1'b0;
      if (mem_req && start_ready) check(1'b0, "R1 ready while busy", 32'(start_ready), 32'd0);
      if (mem_req && mj >= NJOB) check(1'b0, "R1 access without request", mem_addr, 32'd0);
      mem_ack = 1'b0;
      if (mem_req && mj < NJOB) begin
        if (wcnt > 0)
          check(mem_addr == hold_addr && mem_we == hold_we && mem_wdata == hold_data,
                "R7 stall stability", mem_addr, hold_addr);
        hold_addr = mem_addr; hold_we = mem_we; hold_data = mem_wdata;
        if (wcnt < int'(j.wt)) begin
          wcnt++;
        end else begin
          wcnt = 0;
          saved = j.sw ? j.nip : j.cip;
          ewe = (acc_k >= 2);
          ed  = 16'h0;
          case (acc_k)
            0: ea = TB_TBL + {22'd0, j.vec, 2'b00};
            1: ea = TB_TBL + {22'd0, j.vec, 2'b00} + 32'd2;
            2: begin ea = j.ss + {16'd0, j.sp[15:0] - 16'd2}; ed = j.fl; end
            3: begin ea = j.ss + {16'd0, j.sp[15:0] - 16'd4}; ed = j.cs; end
            default: begin ea = j.ss + {16'd0, j.sp[15:0] - 16'd6}; ed = saved; end
          endcase
          if (acc_k < 2) begin
            check(mem_addr == ea && !mem_we, "R2 vector read addr", mem_addr, ea);
          end else begin
            check(mem_addr == ea && mem_we == ewe, "R4 push addr", mem_addr, ea);
            if (acc_k == 4)
              check(mem_wdata == ed, "R5 saved ip", 32'(mem_wdata), 32'(ed));
            else
              check(mem_wdata == ed, "R4 push data", 32'(mem_wdata), 32'(ed));
          end
          mem_ack = 1'b1;
          mem_rdata = rd_model(mem_addr);
          acc_k++;
          if (acc_k == 5) last_prev = 1'b1;
        end
      end
    end
  end

  task automatic drive(input job_t j);
    vec_num = j.vec; soft_int = j.sw; cur_ip = j.cip; next_ip = j.nip;
    cur_cs = j.cs; cur_flags = j.fl; cur_sp = j.sp; ss_base = j.ss;
  endtask

  task automatic scramble();
    // R10: inputs change mid-sequence
    vec_num = ~vec_num; soft_int = ~soft_int; cur_ip = ~cur_ip; next_ip = ~next_ip;
    cur_cs = ~cur_cs; cur_flags = ~cur_flags; cur_sp = ~cur_sp; ss_base = ~ss_base;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(start_ready == 1'b1, "R9 ready", 32'(start_ready), 32'd1);
    check(!mem_req && !done, "R9 idle outputs", {30'd0, mem_req, done}, 32'd0);
    check(new_ip == 0 && new_cs == 0 && new_sp == 0, "R9 results", new_sp, 32'd0);
    active = 1'b1;
    for (int i = 0; i < NJOB; i++) begin
      @(negedge clk);
      drive(JOBS[i]);
      start_valid = 1'b1;
      while (!start_ready) @(negedge clk);
      if (!JOBS[i].b2b) begin
        @(negedge clk);
        scramble();
        start_valid = 1'b0;
        wait (done_cnt == i + 1);
      end
    end
    // R1: idle with changing inputs and no request offered
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      scramble();
    end
    check(!mem_req && start_ready, "R1 quiet idle", {31'd0, mem_req}, 32'd0);
    check(done_cnt == NJOB, "R8 done count", done_cnt, NJOB);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule